// File: doc/BRIEF.md
# Sequential Signed Multiply/Divide Unit

This block is an iterative arithmetic unit for signed two's-complement operands of a parameterised width W (32 by default). A 2-bit op code selects one of four results: the low or the high word of the full 2W-bit product, the quotient, or the remainder. When the unit accepts a request, it records the magnitudes of both operands. It then spends W cycles on either shift-and-add steps (multiply) or restoring compare-and-subtract steps (divide). A final cycle applies the sign to the result.

The caller raises `start` for one cycle with `op`, `x` and `y` valid. It then waits for the single-cycle `done` pulse, which marks `result` as valid. A divide whose divisor is zero is refused when the request is accepted: no iterations run and an error flag comes back with `done` on the next cycle. The unit handles one request at a time and ignores any request made while it is busy.

Top module: `seq_muldiv`

## Requirements
- R1: Op code 2'b00 returns the low W bits of the signed product x*y.
- R2: Op code 2'b01 returns the high W bits of the signed 2W-bit product x*y. When the product is negative, this word is the two's-complement high half, with the borrow from the low half taken into account.
- R3: Op code 2'b10 returns the signed quotient truncated toward zero. It is |x|/|y|, negated when the sign bits of x and y differ. The most negative x divided by -1 therefore wraps back to the most negative value.
- R4: Op code 2'b11 returns the remainder |x| mod |y|, negated when x is negative (the remainder follows the sign of the dividend).
- R5: A divide op (op[1]=1) with y=0 runs no iterations. `done` and `div_zero` are both high in the cycle after the accepting edge, `result` is 0, and `busy` never rises.
- R6: For any other accepted request, `busy` is high from the cycle after the accepting edge until the pulse. `done` rises exactly W+1 clock edges after the accepting edge, and `busy` is low while `done` is high.
- R7: `done` lasts one cycle unless a new request is accepted in that cycle. `result` changes only in a cycle where `done` is high and otherwise holds its last value.
- R8: A `start` raised while `busy` is high is ignored. It changes neither the result nor the timing of the request in progress.
- R9: After reset, `busy`, `done` and `div_zero` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only while idle |
| op | input | 2 | 00 product low, 01 product high, 10 quotient, 11 remainder |
| x | input | W | Multiplicand or dividend (signed) |
| y | input | W | Multiplier or divisor (signed) |
| busy | output | 1 | Iteration or sign fix-up in progress |
| done | output | 1 | One-cycle pulse: result (or error) valid |
| div_zero | output | 1 | With done: the divide was refused for a zero divisor |
| result | output | W | Selected result word |

## Verification
Two situations are hard to reach from the ports. The first is the sign fix-up of the high product word when the low word of the magnitude product is zero, because only then does the borrow carry into the high half. The second is the most-negative operand, whose magnitude needs the full unsigned width. A 4-bit instance is swept over every operand pair and every op code, which hits both situations many times. A 32-bit instance receives directed vectors built around the most negative value, -1 and zero. A second `start` is injected in the middle of a run, carrying a zero-divisor divide that would otherwise complete at once, to show that it cannot disturb the request in progress.

// File: rtl/smd_pkg.sv
package smd_pkg;
  typedef enum logic [1:0] {
    OP_MUL_LO = 2'b00,
    OP_MUL_HI = 2'b01,
    OP_QUO    = 2'b10,
    OP_REM    = 2'b11
  } smd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } smd_state_e;
endpackage

// File: rtl/smd_mul_step.sv
// One shift-add multiply step on a magnitude pair {hi,lo}.
module smd_mul_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] hi_n,
  output logic [W-1:0] lo_n
);
  logic [W:0] sum;

  always_comb begin
    sum  = lo[0] ? ({1'b0, hi} + {1'b0, mcand}) : {1'b0, hi};
    hi_n = sum[W:1];
    lo_n = {sum[0], lo[W-1:1]};
  end
endmodule

// File: rtl/smd_div_step.sv
// One restoring divide step: remainder in rem, dividend/quotient in quo.
module smd_div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] rem_n,
  output logic [W-1:0] quo_n
);
  logic [W:0]   sh;
  logic [W-1:0] diff;
  logic         fits;

  always_comb begin
    sh    = {rem, quo[W-1]};
    fits  = sh >= {1'b0, dvsr};
    diff  = sh[W-1:0] - dvsr;
    rem_n = fits ? diff : sh[W-1:0];
    quo_n = {quo[W-2:0], fits};
  end
endmodule

// File: rtl/smd_sign_fix.sv
// Applies the sign to the magnitude result and picks the requested word.
module smd_sign_fix #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic         neg_res,
  input  logic         neg_dvd,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] negate(input logic [W-1:0] v);
    return ~v + ONE;
  endfunction

  // High half of the negated 2W-bit value: the +1 reaches it only when lo is 0.
  function automatic logic [W-1:0] neg_high(input logic [W-1:0] h, input logic [W-1:0] l);
    return (l == '0) ? (~h + ONE) : ~h;
  endfunction

  logic [W-1:0] p_lo, p_hi, q_s, r_s;

  always_comb begin
    p_lo = neg_res ? negate(lo) : lo;
    p_hi = neg_res ? neg_high(hi, lo) : hi;
    q_s  = neg_res ? negate(lo) : lo;
    r_s  = neg_dvd ? negate(hi) : hi;
    case (op)
      2'b00:   res = p_lo;
      2'b01:   res = p_hi;
      2'b10:   res = q_s;
      default: res = r_s;
    endcase
  end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import smd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] result
);
  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    return v[W-1] ? (~v + ONE) : v;
  endfunction

  smd_state_e       state;
  logic [CNT_W-1:0] cnt;
  smd_op_e          op_q;
  logic [W-1:0]     hi_q, lo_q, arg_q;
  logic             neg_res_q, neg_dvd_q;

  // Named internal events
  logic accept, dz_req, last_step;
  logic [W-1:0] m_hi, m_lo, d_hi, d_lo, fix_res;

  assign accept    = start && (state == ST_IDLE);
  assign dz_req    = op[1] && (y == '0);
  assign last_step = (state == ST_RUN) && (cnt == LAST);
  assign busy      = (state != ST_IDLE);

  smd_mul_step #(.W(W)) u_mul (
    .hi(hi_q), .lo(lo_q), .mcand(arg_q), .hi_n(m_hi), .lo_n(m_lo)
  );

  smd_div_step #(.W(W)) u_div (
    .rem(hi_q), .quo(lo_q), .dvsr(arg_q), .rem_n(d_hi), .quo_n(d_lo)
  );

  smd_sign_fix #(.W(W)) u_fix (
    .op(op_q), .hi(hi_q), .lo(lo_q), .neg_res(neg_res_q),
    .neg_dvd(neg_dvd_q), .res(fix_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      op_q      <= OP_MUL_LO;
      hi_q      <= '0;
      lo_q      <= '0;
      arg_q     <= '0;
      neg_res_q <= 1'b0;
      neg_dvd_q <= 1'b0;
      result    <= '0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
    end else begin
      done     <= 1'b0;
      div_zero <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dz_req) begin
              done     <= 1'b1;
              div_zero <= 1'b1;
              result   <= '0;
            end else begin
              state     <= ST_RUN;
              cnt       <= '0;
              op_q      <= smd_op_e'(op);
              hi_q      <= '0;
              lo_q      <= mag(x);
              arg_q     <= mag(y);
              neg_res_q <= x[W-1] ^ y[W-1];
              neg_dvd_q <= x[W-1];
            end
          end
        end
        ST_RUN: begin
          hi_q <= op_q[1] ? d_hi : m_hi;
          lo_q <= op_q[1] ? d_lo : m_lo;
          cnt  <= cnt + CNT_W'(1);
          if (last_step) state <= ST_FIX;
        end
        ST_FIX: begin
          result <= fix_res;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  dz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (done && (result == '0)));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(busy)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(start)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R6
  step_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (busy && !done));
endmodule

// File: tb/seq_muldiv_bench.sv
module seq_muldiv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 4;
  localparam int WB = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sel = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] x = '0;
  logic [31:0] y = '0;

  logic          busy_a, done_a, dz_a;
  logic [WA-1:0] res_a;
  logic          busy_b, done_b, dz_b;
  logic [WB-1:0] res_b;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seq_muldiv #(.W(WA)) u_seq_muldiv_nib (
    .clk(clk), .rst_n(rst_n), .start(start && !sel), .op(op),
    .x(x[WA-1:0]), .y(y[WA-1:0]),
    .busy(busy_a), .done(done_a), .div_zero(dz_a), .result(res_a)
  );

  seq_muldiv #(.W(WB)) u_seq_muldiv (
    .clk(clk), .rst_n(rst_n), .start(start && sel), .op(op),
    .x(x), .y(y),
    .busy(busy_b), .done(done_b), .div_zero(dz_b), .result(res_b)
  );

  logic   cur_busy, cur_done, cur_dz;
  longint cur_res;
  always_comb begin
    cur_busy = sel ? busy_b : busy_a;
    cur_done = sel ? done_b : done_a;
    cur_dz   = sel ? dz_b   : dz_a;
    cur_res  = sel ? longint'(res_b) : longint'(res_a);
  end

  function automatic longint sext(int w, longint v);
    longint m = (longint'(1) << w) - 1;
    longint t = v & m;
    if (t >= (longint'(1) << (w - 1))) t = t - (longint'(1) << w);
    return t;
  endfunction

  // Expected value from the signed arithmetic the requirements describe.
  function automatic longint expect_val(int w, logic [1:0] o, longint xv, longint yv);
    longint m  = (longint'(1) << w) - 1;
    longint xs = sext(w, xv);
    longint ys = sext(w, yv);
    longint ax = (xs < 0) ? -xs : xs;
    longint ay = (ys < 0) ? -ys : ys;
    longint p  = xs * ys;
    longint q, r;
    case (o)
      2'b00: return p & m;
      2'b01: return (p >>> w) & m;
      2'b10: begin
        q = ax / ay;
        if ((xs < 0) != (ys < 0)) q = -q;
        return q & m;
      end
      default: begin
        r = ax % ay;
        if (xs < 0) r = -r;
        return r & m;
      end
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] o, bit dz);
    if (dz) return "R5";
    case (o)
      2'b00: return "R1/R6";
      2'b01: return "R2/R6";
      2'b10: return "R3/R6";
      default: return "R4/R6";
    endcase
  endfunction

  task automatic apply(input logic s, input logic [1:0] o, input logic [31:0] xv, input logic [31:0] yv);
    int     w = s ? WB : WA;
    longint m = (longint'(1) << w) - 1;
    bit     dz = o[1] && ((longint'(yv) & m) == 0);
    longint exp_r = dz ? 0 : expect_val(w, o, longint'(xv), longint'(yv));
    int     exp_n = dz ? 0 : w + 1;
    int     n = 0;
    bit     bad_busy = 0;
    longint got;
    @(negedge clk);
    sel = s; op = o; x = xv; y = yv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!cur_done && n < w + 6) begin
      if (!cur_busy) bad_busy = 1;
      @(negedge clk);
      n++;
    end
    if (dz && cur_busy) bad_busy = 1;
    got = cur_res;
    checks++;
    if (got != exp_r || n != exp_n || cur_dz != dz || bad_busy || (cur_done && cur_busy)) begin
      fails++;
      $display("FAIL %s w=%0d op=%0d x=%h y=%h: result %h exp %h, latency %0d exp %0d, div_zero %0b exp %0b, busy_err %0b",
               tag_of(o, dz), w, o, xv, yv, got, exp_r, n, exp_n, cur_dz, dz, bad_busy);
    end
    // R7: pulse ends after one cycle and the result holds
    @(negedge clk);
    checks++;
    if (cur_done || cur_res != got || cur_dz) begin
      fails++;
      $display("FAIL R7 w=%0d op=%0d: done %0b exp 0, result %h exp %h, div_zero %0b exp 0",
               w, o, cur_done, cur_res, got, cur_dz);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (busy_a || done_a || dz_a || res_a != '0 || busy_b || done_b || dz_b || res_b != '0) begin
      fails++;
      $display("FAIL R9: busy %0b%0b done %0b%0b dz %0b%0b res %h/%h exp all 0",
               busy_a, busy_b, done_a, done_b, dz_a, dz_b, res_a, res_b);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R8: a second start mid-run (a zero-divisor divide) is ignored
    sel = 1'b0; op = 2'b00; x = 32'd5; y = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    op = 2'b11; x = 32'd7; y = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; x = '0;
    n = 3;
    while (!done_a && n < 20) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (n != WA + 1 || res_a != 4'hF || dz_a) begin
      fails++;
      $display("FAIL R8: latency %0d exp %0d, result %h exp f, div_zero %0b exp 0", n, WA + 1, res_a, dz_a);
    end
    @(negedge clk);

    // Exhaustive sweep of the 4-bit instance
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(1'b0, o[1:0], 32'(a), 32'(b));

    // Directed corners on the 32-bit instance
    for (int o = 0; o < 4; o++) begin
      apply(1'b1, o[1:0], 32'h8000_0000, 32'hFFFF_FFFF);
      apply(1'b1, o[1:0], 32'h8000_0000, 32'h8000_0000);
      apply(1'b1, o[1:0], 32'hFFFF_FFF9, 32'd3);
      apply(1'b1, o[1:0], 32'd7, 32'hFFFF_FFFD);
      apply(1'b1, o[1:0], 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      apply(1'b1, o[1:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      apply(1'b1, o[1:0], 32'd123456, 32'hFFFF_FCEB);
      apply(1'b1, o[1:0], 32'h0001_0000, 32'hFFFF_0000);
      apply(1'b1, o[1:0], 32'h1234_5678, 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule